// File: doc/BRIEF.md
# I2C Master Bus-Condition and Clock Sequencer

This block is the master-side timing engine of a byte-oriented I2C controller. It puts START, repeated START and STOP conditions on the bus and generates SCL for each byte transfer. A separate byte shifter supplies the data bit through `dataSdaLow`. The control register supplies level requests `staReq` and `stoReq` and a 3-bit rate select. The interrupt flag comes back in on `siFlag`. After every START and every completed byte the block parks with SCL held low and emits a one-cycle done pulse. It stays parked until the interrupt flag has been seen set and then cleared again.

Both bus lines are handled as open drain. The block only asserts "pull low" enables and never drives a line high. It also watches the synchronised bus lines to track whether any master holds the bus. A START request on a busy bus waits for a STOP. After that STOP it waits a further bus-free interval before taking the bus.

The phase timing comes from an oscillator tick of `TICK_DIV` core cycles. This stands in for a 9 MHz time base. Each SCL half period is a preset number of ticks.

Top module: `i2c_cond_sequencer`

## Requirements
- R1: After reset, and whenever `masterMode` is low, `sclLow` and `sdaLow` are both 0, and `busBusy` is 0 out of reset.
- R2: With `staReq` high and the bus free, the block pulls SDA low while SCL is released, then pulls SCL low, then pulses `startDone` with both lines low, and `masterMode` goes to 1.
- R3: Clearing `siFlag` in the parked state with no STOP or repeated START due runs exactly 9 SCL pulses, then pulses `byteDone` and holds SCL low.
- R4: SCL half period H in oscillator ticks for `clkSel` 0..7 is 14, 16, 21, 31, 51, 77, 103, 125. The low phase of a bit lasts H*TICK_DIV+1 core cycles. The high phase lasts H*TICK_DIV core cycles counted from when SCL is first sampled high, plus the synchroniser delay.
- R5: If another device holds SCL low after the block releases it, the high-phase count starts only once SCL is seen high.
- R6: After a done pulse, SCL stays low for as long as `siFlag` is high. The block proceeds only once `siFlag` has been seen high and is then low.
- R7: `busBusy` sets on a bus START (SDA falling while SCL high) and clears on a bus STOP (SDA rising while SCL high).
- R8: A START request while `busBusy` is 1 leaves both lines untouched. After the STOP, START begins no sooner than BUF_TICKS*TICK_DIV core cycles later.
- R9: In master mode, once at least one byte has completed since the last START, `staReq` high when `siFlag` clears produces a repeated START: SDA rises while SCL is low, SCL rises, SDA falls while SCL is high, and `startDone` pulses with no STOP on the bus.
- R10: `staReq` high with no byte completed since the last START is ignored, and a byte is clocked instead.
- R11: `stoReq` high when `siFlag` clears in master mode produces a STOP (SDA rising while SCL high), pulses `stopDone`, and drops `masterMode`.
- R12: With both `staReq` and `stoReq` high, the block issues a STOP, waits at least the bus-free interval, then issues a fresh START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| staReq | input | 1 | START requested (level) |
| stoReq | input | 1 | STOP requested (level) |
| clkSel | input | 3 | SCL rate select |
| siFlag | input | 1 | Interrupt flag pending; stretches SCL low |
| dataSdaLow | input | 1 | Data bit from the byte shifter, 1 pulls SDA low |
| sclIn | input | 1 | Sampled SCL bus level |
| sdaIn | input | 1 | Sampled SDA bus level |
| sclLow | output | 1 | Pull SCL low |
| sdaLow | output | 1 | Pull SDA low |
| masterMode | output | 1 | Block owns the bus |
| busBusy | output | 1 | Bus held by some master |
| startDone | output | 1 | START or repeated START completed (pulse) |
| stopDone | output | 1 | STOP completed (pulse) |
| byteDone | output | 1 | Nine SCL pulses completed (pulse) |
| bitSample | output | 1 | End of an SCL high phase, data valid (pulse) |
| bitNext | output | 1 | SCL low phase begins, shifter may change data (pulse) |

## Verification
A wrong sequencer state shows up on the bus lines within one SCL half period. Typical symptoms are a missing or extra SCL pulse before `byteDone`, a STOP where a repeated START was due, or SCL released while the interrupt flag is still pending. A stale bus monitor or bus-free counter shows up in when the next START begins relative to the last STOP, and is visible as soon as a START is requested. Phase-timer faults change the measured low and high lengths of every bit.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ST_FALL,
    S_ST_CLAMP,
    S_HOLD,
    S_BIT_LOW,
    S_BIT_HIGH,
    S_RS_PREP,
    S_RS_RISE,
    S_SP_PREP,
    S_SP_RISE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHalf;
    logic clrBits;
    logic incBits;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic halfDone;
    logic sclHigh;
    logic busFree;
    logic lastBit;
  } dpStat_t;

  localparam int HALF_W = 8;

  // half SCL period in oscillator ticks for each rate select
  function automatic logic [HALF_W-1:0] halfTicks(input logic [2:0] sel);
    case (sel)
      3'd0:    halfTicks = 8'd14;
      3'd1:    halfTicks = 8'd16;
      3'd2:    halfTicks = 8'd21;
      3'd3:    halfTicks = 8'd31;
      3'd4:    halfTicks = 8'd51;
      3'd5:    halfTicks = 8'd77;
      3'd6:    halfTicks = 8'd103;
      default: halfTicks = 8'd125;
    endcase
  endfunction

endpackage

// File: rtl/i2c_seq_datapath.sv
module i2c_seq_datapath
  import i2c_seq_pkg::*;
#(
  parameter int TICK_DIV      = 14,
  parameter int BUF_TICKS     = 12,
  parameter int BITS_PER_XFER = 9,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] clkSel,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  dpCtrl_t    ctrl,
  output dpStat_t    stat,
  output logic       busBusy
);

  localparam int PRE_W      = $clog2(TICK_DIV) + 1;
  localparam int BUF_CYCLES = BUF_TICKS * TICK_DIV;
  localparam int FREE_W     = $clog2(BUF_CYCLES + 1);
  localparam int BIT_W      = $clog2(BITS_PER_XFER + 1);

  // input synchronisers
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync[0] <= sclIn;
      sdaSync[0] <= sdaIn;
    end
  end

  genvar g;
  generate
    for (g = 1; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else begin
          sclSync[g] <= sclSync[g-1];
          sdaSync[g] <= sdaSync[g-1];
        end
      end
    end
  endgenerate

  logic sclNow, sdaNow, sclPrev, sdaPrev;
  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  // bus condition detection
  logic startSeen, stopSeen;
  assign startSeen = sclNow && sclPrev && sdaPrev && !sdaNow;
  assign stopSeen  = sclNow && sclPrev && !sdaPrev && sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busBusy <= 1'b0;
    else if (startSeen) busBusy <= 1'b1;
    else if (stopSeen)  busBusy <= 1'b0;
  end

  // bus-free interval counter, in core cycles
  logic [FREE_W-1:0] freeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      freeCnt <= FREE_W'(BUF_CYCLES);
    else if (stopSeen)
      freeCnt <= '0;
    else if (!busBusy && (freeCnt != FREE_W'(BUF_CYCLES)))
      freeCnt <= freeCnt + 1'b1;
  end

  // half-period timer with restartable prescaler
  logic [PRE_W-1:0]  preCnt;
  logic [HALF_W-1:0] halfCnt;
  logic              tick;
  assign tick = (preCnt == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      halfCnt <= '0;
    end else if (ctrl.loadHalf) begin
      preCnt  <= '0;
      halfCnt <= halfTicks(clkSel);
    end else if (halfCnt != '0) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) halfCnt <= halfCnt - 1'b1;
    end
  end

  // SCL pulse counter
  logic [BIT_W-1:0] bitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bitCnt <= '0;
    else if (ctrl.clrBits) bitCnt <= '0;
    else if (ctrl.incBits) bitCnt <= bitCnt + 1'b1;
  end

  assign stat.halfDone = (halfCnt == '0);
  assign stat.sclHigh  = sclNow;
  assign stat.busFree  = !busBusy && (freeCnt == FREE_W'(BUF_CYCLES));
  assign stat.lastBit  = (bitCnt == BIT_W'(BITS_PER_XFER - 1));

endmodule

// File: rtl/i2c_seq_control.sv
module i2c_seq_control
  import i2c_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    staReq,
  input  logic    stoReq,
  input  logic    siFlag,
  input  logic    dataSdaLow,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    sclLow,
  output logic    sdaLow,
  output logic    masterMode,
  output logic    startDone,
  output logic    stopDone,
  output logic    byteDone,
  output logic    bitSample,
  output logic    bitNext
);

  seqState_t state, stateNext;
  logic siSeen, bytesMoved;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    startDone = 1'b0;
    stopDone  = 1'b0;
    byteDone  = 1'b0;
    bitSample = 1'b0;
    bitNext   = 1'b0;
    case (state)
      S_IDLE: begin
        if (staReq && stat.busFree) begin
          stateNext     = S_ST_FALL;
          ctrl.loadHalf = 1'b1;
        end
      end
      S_ST_FALL: begin
        if (stat.halfDone) begin
          stateNext     = S_ST_CLAMP;
          ctrl.loadHalf = 1'b1;
        end
      end
      S_ST_CLAMP: begin
        if (stat.halfDone) begin
          stateNext    = S_HOLD;
          startDone    = 1'b1;
          ctrl.clrBits = 1'b1;
        end
      end
      S_HOLD: begin
        if (siSeen && !siFlag) begin
          ctrl.loadHalf = 1'b1;
          if (stoReq) begin
            stateNext = S_SP_PREP;
          end else if (staReq && bytesMoved) begin
            stateNext = S_RS_PREP;
          end else begin
            stateNext    = S_BIT_LOW;
            ctrl.clrBits = 1'b1;
            bitNext      = 1'b1;
          end
        end
      end
      S_BIT_LOW: begin
        if (stat.halfDone) begin
          stateNext     = S_BIT_HIGH;
          ctrl.loadHalf = 1'b1;
        end
      end
      S_BIT_HIGH: begin
        if (!stat.sclHigh) begin
          ctrl.loadHalf = 1'b1;
        end else if (stat.halfDone) begin
          ctrl.incBits = 1'b1;
          bitSample    = 1'b1;
          if (stat.lastBit) begin
            stateNext = S_HOLD;
            byteDone  = 1'b1;
          end else begin
            stateNext     = S_BIT_LOW;
            ctrl.loadHalf = 1'b1;
            bitNext       = 1'b1;
          end
        end
      end
      S_RS_PREP: begin
        if (stat.halfDone) begin
          stateNext     = S_RS_RISE;
          ctrl.loadHalf = 1'b1;
        end
      end
      S_RS_RISE: begin
        if (!stat.sclHigh) begin
          ctrl.loadHalf = 1'b1;
        end else if (stat.halfDone) begin
          stateNext     = S_ST_FALL;
          ctrl.loadHalf = 1'b1;
        end
      end
      S_SP_PREP: begin
        if (stat.halfDone) begin
          stateNext     = S_SP_RISE;
          ctrl.loadHalf = 1'b1;
        end
      end
      S_SP_RISE: begin
        if (!stat.sclHigh) begin
          ctrl.loadHalf = 1'b1;
        end else if (stat.halfDone) begin
          stateNext = S_IDLE;
          stopDone  = 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // interrupt handshake: leave the parked state only after the flag was raised and cleared
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         siSeen <= 1'b0;
    else if (startDone || byteDone)    siSeen <= 1'b0;
    else if (state == S_HOLD && siFlag) siSeen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   bytesMoved <= 1'b0;
    else if (byteDone)                           bytesMoved <= 1'b1;
    else if (stopDone || stateNext == S_RS_PREP) bytesMoved <= 1'b0;
  end

  // open-drain line enables
  always_comb begin
    sclLow = 1'b0;
    sdaLow = 1'b0;
    case (state)
      S_ST_FALL:  sdaLow = 1'b1;
      S_ST_CLAMP: begin sclLow = 1'b1; sdaLow = 1'b1; end
      S_HOLD:     begin sclLow = 1'b1; sdaLow = dataSdaLow; end
      S_BIT_LOW:  begin sclLow = 1'b1; sdaLow = dataSdaLow; end
      S_BIT_HIGH: sdaLow = dataSdaLow;
      S_RS_PREP:  sclLow = 1'b1;
      S_SP_PREP:  begin sclLow = 1'b1; sdaLow = 1'b1; end
      S_SP_RISE:  sdaLow = 1'b1;
      default: ;
    endcase
  end

  assign masterMode = (state != S_IDLE);

endmodule

// File: rtl/i2c_cond_sequencer.sv
module i2c_cond_sequencer
  import i2c_seq_pkg::*;
#(
  parameter int TICK_DIV      = 14,
  parameter int BUF_TICKS     = 12,
  parameter int BITS_PER_XFER = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       staReq,
  input  logic       stoReq,
  input  logic [2:0] clkSel,
  input  logic       siFlag,
  input  logic       dataSdaLow,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclLow,
  output logic       sdaLow,
  output logic       masterMode,
  output logic       busBusy,
  output logic       startDone,
  output logic       stopDone,
  output logic       byteDone,
  output logic       bitSample,
  output logic       bitNext
);

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  i2c_seq_datapath #(
    .TICK_DIV(TICK_DIV),
    .BUF_TICKS(BUF_TICKS),
    .BITS_PER_XFER(BITS_PER_XFER),
    .SYNC_STAGES(2)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .clkSel(clkSel),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .ctrl(dpCtrl),
    .stat(dpStat),
    .busBusy(busBusy)
  );

  i2c_seq_control uCtl (
    .clk(clk),
    .rstN(rstN),
    .staReq(staReq),
    .stoReq(stoReq),
    .siFlag(siFlag),
    .dataSdaLow(dataSdaLow),
    .stat(dpStat),
    .ctrl(dpCtrl),
    .sclLow(sclLow),
    .sdaLow(sdaLow),
    .masterMode(masterMode),
    .startDone(startDone),
    .stopDone(stopDone),
    .byteDone(byteDone),
    .bitSample(bitSample),
    .bitNext(bitNext)
  );

endmodule

// File: rtl/i2c_cond_sequencer_chk.sv
module i2c_cond_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic siFlag,
  input logic sclLow,
  input logic sdaLow,
  input logic masterMode,
  input logic busBusy,
  input logic startDone,
  input logic stopDone,
  input logic byteDone
);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (!sclLow && !sdaLow));

  // R2
  start_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDone |-> (sclLow && sdaLow && masterMode));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDone |=> (!sclLow && !sdaLow && !masterMode));

  // R6
  si_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && sclLow && siFlag && $past(siFlag)) |=> sclLow);

  // R8
  start_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(masterMode) |-> $past(!busBusy));

  // R3
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startDone, stopDone, byteDone}));

endmodule

bind i2c_cond_sequencer i2c_cond_sequencer_chk uChk (
  .clk(clk),
  .rstN(rstN),
  .siFlag(siFlag),
  .sclLow(sclLow),
  .sdaLow(sdaLow),
  .masterMode(masterMode),
  .busBusy(busBusy),
  .startDone(startDone),
  .stopDone(stopDone),
  .byteDone(byteDone)
);

// File: tb/tb_i2c_cond_sequencer.sv
`timescale 1ns/1ps
module tb_i2c_cond_sequencer;

  localparam int TD  = 2;
  localparam int BT  = 12;
  localparam int BUF = BT * TD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic staReq = 1'b0, stoReq = 1'b0, siFlag = 1'b0, dataSdaLow = 1'b0;
  logic [2:0] clkSel = 3'd0;
  logic extScl = 1'b0, extSda = 1'b0;
  logic scl, sda;
  logic sclLow, sdaLow, masterMode, busBusy, startDone, stopDone, byteDone, bitSample, bitNext;

  assign scl = !(sclLow || extScl);
  assign sda = !(sdaLow || extSda);

  always #4 clk = ~clk;

  i2c_cond_sequencer #(.TICK_DIV(TD), .BUF_TICKS(BT), .BITS_PER_XFER(9)) dut (
    .clk(clk), .rstN(rstN), .staReq(staReq), .stoReq(stoReq), .clkSel(clkSel),
    .siFlag(siFlag), .dataSdaLow(dataSdaLow), .sclIn(scl), .sdaIn(sda),
    .sclLow(sclLow), .sdaLow(sdaLow), .masterMode(masterMode), .busBusy(busBusy),
    .startDone(startDone), .stopDone(stopDone), .byteDone(byteDone),
    .bitSample(bitSample), .bitNext(bitNext)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  bit finished = 0;

  // bus monitor
  int busStarts = 0, busStops = 0, sclRises = 0;
  int lastStartCyc = 0, lastStopCyc = 0, riseCyc = 0, fallCyc = 0, lowLen = 0, highLen = 0;
  logic prevScl = 1'b1, prevSda = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevScl && scl && prevSda && !sda) begin busStarts++; lastStartCyc = cyc; end
      if (prevScl && scl && !prevSda && sda) begin busStops++;  lastStopCyc  = cyc; end
      if (!prevScl && scl) begin sclRises++; riseCyc = cyc; lowLen = cyc - fallCyc; end
      if (prevScl && !scl) begin fallCyc = cyc; highLen = cyc - riseCyc; end
    end
    prevScl = scl;
    prevSda = sda;
  end

  function automatic int expHalf(input int sel);
    case (sel)
      0: return 14; 1: return 16; 2: return 21; 3: return 31;
      4: return 51; 5: return 77; 6: return 103; default: return 125;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // wait for a done pulse; returns 1 for start, 2 for stop, 3 for byte, 0 on timeout
  task automatic waitDone(output int which);
    which = 0;
    for (int i = 0; i < 20000; i++) begin
      step();
      if (startDone) begin which = 1; break; end
      if (stopDone)  begin which = 2; break; end
      if (byteDone)  begin which = 3; break; end
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (4) step();
    rstN = 1'b1;
    step();
    chk(!sclLow && !sdaLow, "R1 lines released after reset", {sclLow, sdaLow}, 0);
    chk(!masterMode && !busBusy, "R1 idle flags after reset", {masterMode, busBusy}, 0);
  endtask

  task automatic t_start();
    int s0, w;
    s0 = busStarts;
    clkSel = 3'd0;
    staReq = 1'b1;
    waitDone(w);
    chk(w == 1, "R2 startDone pulse", w, 1);
    chk(busStarts == s0 + 1, "R2 START on bus", busStarts - s0, 1);
    chk(sclLow && sdaLow && masterMode, "R2 lines low and master", {sclLow, sdaLow, masterMode}, 7);
    siFlag = 1'b1;
    repeat (6) step();
    chk(busBusy, "R7 busy after START", busBusy, 1);
  endtask

  task automatic t_siHold();
    int rel = 0;
    for (int i = 0; i < 300; i++) begin
      step();
      if (!sclLow || scl) rel++;
    end
    chk(rel == 0, "R6 SCL held while SI set", rel, 0);
  endtask

  task automatic t_byte(input int sel, input string tag);
    int r0, s0, w, h;
    h = expHalf(sel) * TD;
    clkSel = sel[2:0];
    r0 = sclRises;
    s0 = busStarts;
    siFlag = 1'b0;
    waitDone(w);
    chk(w == 3, {tag, " byteDone pulse"}, w, 3);
    chk(sclRises - r0 == 9, "R3 nine SCL pulses", sclRises - r0, 9);
    chk(busStarts == s0, {tag, " no START during byte"}, busStarts - s0, 0);
    chk(lowLen >= h && lowLen <= h + 3, "R4 low phase length", lowLen, h + 1);
    chk(highLen >= h + 1 && highLen <= h + 5, "R4 high phase length", highLen, h + 3);
    siFlag = 1'b1;
    repeat (20) step();
    chk(sclLow, "R3 SCL held low after byte", sclLow, 1);
  endtask

  task automatic t_repStart();
    int s0, p0, w, drops = 0;
    s0 = busStarts;
    p0 = busStops;
    staReq = 1'b1;
    siFlag = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      step();
      if (!masterMode) drops++;
      if (startDone) begin w = 1; break; end
      if (byteDone || stopDone) begin w = 3; break; end
    end
    chk(w == 1, "R9 repeated START done", w, 1);
    chk(busStarts == s0 + 1 && busStops == p0, "R9 START without STOP", busStarts - s0, 1);
    chk(drops == 0, "R9 master kept", drops, 0);
    siFlag = 1'b1;
    repeat (4) step();
  endtask

  task automatic t_stretch();
    int h, n = 0, drv = 0, w;
    h = expHalf(7) * TD;
    clkSel = 3'd7;
    siFlag = 1'b0;
    for (int i = 0; i < 5000 && sclLow; i++) step();
    extScl = 1'b1;
    for (int i = 0; i < 150; i++) begin
      step();
      if (sclLow) drv++;
    end
    chk(drv == 0, "R5 no progress while SCL held by other", drv, 0);
    extScl = 1'b0;
    while (!sclLow && n < 5000) begin step(); n++; end
    chk(n >= h && n <= h + 6, "R5 high phase after release", n, h + 3);
    waitDone(w);
    chk(w == 3, "R5 byte completes after stretch", w, 3);
    siFlag = 1'b1;
    repeat (4) step();
  endtask

  task automatic t_stop();
    int p0, w;
    p0 = busStops;
    staReq = 1'b0;
    stoReq = 1'b1;
    siFlag = 1'b0;
    waitDone(w);
    stoReq = 1'b0;
    chk(w == 2, "R11 stopDone pulse", w, 2);
    repeat (6) step();
    chk(busStops == p0 + 1, "R11 STOP on bus", busStops - p0, 1);
    chk(!masterMode && !sclLow && !sdaLow, "R11 master released", {masterMode, sclLow, sdaLow}, 0);
    chk(!busBusy, "R7 busy cleared by STOP", busBusy, 0);
  endtask

  task automatic t_busyWait();
    int drv = 0, w, gap;
    repeat (BUF + 10) step();
    extSda = 1'b1;
    repeat (6) step();
    chk(busBusy, "R7 busy on foreign START", busBusy, 1);
    staReq = 1'b1;
    for (int i = 0; i < 400; i++) begin
      step();
      if (sdaLow || sclLow || masterMode) drv++;
    end
    chk(drv == 0, "R8 no drive on busy bus", drv, 0);
    extSda = 1'b0;
    waitDone(w);
    chk(w == 1, "R8 START after bus freed", w, 1);
    gap = lastStartCyc - lastStopCyc;
    chk(gap >= BUF && gap <= BUF + 8, "R8 bus-free wait", gap, BUF + 4);
    siFlag = 1'b1;
    staReq = 1'b0;
    repeat (4) step();
  endtask

  task automatic t_staSto();
    int p0, w, gap;
    p0 = busStops;
    staReq = 1'b1;
    stoReq = 1'b1;
    siFlag = 1'b0;
    waitDone(w);
    chk(w == 2, "R12 STOP first", w, 2);
    stoReq = 1'b0;
    waitDone(w);
    chk(w == 1, "R12 then START", w, 1);
    chk(busStops == p0 + 1, "R12 STOP on bus", busStops - p0, 1);
    gap = lastStartCyc - lastStopCyc;
    chk(gap >= BUF && gap <= BUF + 8, "R12 bus-free gap", gap, BUF + 4);
    siFlag = 1'b1;
    staReq = 1'b0;
    repeat (4) step();
  endtask

  initial begin
    t_reset();
    t_start();
    t_siHold();
    t_byte(0, "R10");   // staReq still high, no byte yet: byte is clocked
    t_repStart();
    staReq = 1'b0;
    t_byte(3, "R3");
    t_stretch();
    t_stop();
    t_busyWait();
    t_byte(1, "R4");
    t_staSto();
    t_stop();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule